// File: doc/BRIEF.md
# Invalidation Acknowledgement Write Tracker

The tracker sits beside a processor's cache controller in a directory-based system. In that system an interconnect delivers invalidations to sharers along paths of differing length, so a store has no single point at which every processor sees it. The controller hands each store that needs invalidations to the tracker, along with its address and the number of sharers the directory reported. The tracker gives the store a small tag. Invalidation acknowledgements come back tagged, in any order and after any delay. The tracker counts them down per store and reports the store complete only once the last one has arrived.

While a store is incomplete, the tracker holds off any read of that store's address. No processor can then see the new value while another can still see the old one, and this makes the store behave atomically. In ordered mode it also holds off every access from the processor until all tracked stores have completed. That gives the strict "each access waits for the previous one" discipline. The processor's candidate access is presented on a check port, and the tracker answers on the same cycle with a stall.

Top module: `inval_ack_tracker`

## Requirements
- R1: After reset no entry is busy, `wr_ready` is 1, and `stall`, `ack_err` and every bit of `done_vec` are 0.
- R2: An accepted store takes the lowest-numbered free entry, and `wr_tag` shows that entry's tag on the cycle of the request. When all entries are busy, `wr_ready` is 0 and a request is ignored: no entry changes and no done pulse appears.
- R3: A store accepted with sharer count N>0 completes on the cycle its N-th acknowledgement arrives, whatever the order of acknowledgements to other tags. On that cycle `done_vec[tag]` is 1 for exactly one cycle, and the entry is free on the next cycle.
- R4: A store accepted with sharer count 0 raises `done_vec[tag]` on the cycle it is accepted and leaves the entry free.
- R5: A read check (`acc_valid`=1, `acc_write`=0) whose address equals the address of any busy entry raises `stall` on that same cycle.
- R6: In ordered mode (`ordered_mode`=1), any checked access stalls while any entry is busy. With `ordered_mode`=0, writes and reads to other addresses do not stall.
- R7: A store request and an acknowledgement for a different, busy entry in the same cycle both take effect.
- R8: An acknowledgement whose tag names a free entry sets `ack_err`, which stays set until reset. It changes no entry's count.
- R9: An entry freed by completion can be allocated again from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ordered_mode | input | 1 | 1: every access waits for all stores to complete |
| wr_start | input | 1 | Store tracking request |
| wr_addr | input | ADDR_W | Address of the store |
| wr_sharers | input | CNT_W | Number of invalidation acknowledgements expected |
| wr_ready | output | 1 | A free entry exists; the request is accepted |
| wr_tag | output | TAG_W | Tag given to the request this cycle |
| ack_valid | input | 1 | An acknowledgement arrives |
| ack_tag | input | TAG_W | Tag of the store being acknowledged |
| acc_valid | input | 1 | Processor access presented for checking |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_addr | input | ADDR_W | Address of the checked access |
| done_vec | output | ENTRIES | One-cycle completion pulse per entry |
| stall | output | 1 | Checked access must wait |
| ack_err | output | 1 | Sticky flag: acknowledgement for a free entry |

## Verification
The assertions assume that every input is known after reset and that the directory never reports more sharers than will actually acknowledge. A stray acknowledgement is legal input: the assertions treat it as an error to flag, not as a protocol breach. The stimulus sends random acknowledgements only to tags that the bench's own model shows as busy, with sharer counts kept within the counter range. Stray acknowledgements appear only in a dedicated phase that is followed by a reset.

// File: rtl/iat_pkg.sv
package iat_pkg;

  // Index of the lowest clear bit among the first n bits; n when all are set.
  function automatic int unsigned lowest_clear(input logic [31:0] vec, input int unsigned n);
    int unsigned r;
    r = n;
    for (int i = 31; i >= 0; i--) begin
      if (i < int'(n) && !vec[i]) r = i;
    end
    return r;
  endfunction

  // True when the entry still expects exactly one acknowledgement.
  function automatic logic last_ack(input logic [31:0] remaining);
    return remaining == 32'd1;
  endfunction

endpackage

// File: rtl/iat_alloc.sv
module iat_alloc #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] busy,
  output logic               free_any,
  output logic [TAG_W-1:0]   free_tag,
  output logic [ENTRIES-1:0] free_onehot
);
  import iat_pkg::*;

  int unsigned pick;

  always_comb begin
    pick        = lowest_clear(32'(busy), ENTRIES);
    free_any    = (pick < ENTRIES);
    free_tag    = free_any ? TAG_W'(pick) : '0;
    free_onehot = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (free_any && pick == i) free_onehot[i] = 1'b1;
    end
  end

  always_comb begin
    assert_pick_free_R2: assert (!free_any || (free_onehot & busy) == '0);
  end
endmodule

// File: rtl/iat_entry.sv
module iat_entry #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [CNT_W-1:0]  alloc_cnt,
  input  logic              ack_hit,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  remaining,
  output logic              done
);
  import iat_pkg::*;

  always_comb done = ack_hit && last_ack(32'(remaining));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      addr      <= '0;
      remaining <= '0;
    end else if (alloc_en) begin
      busy      <= 1'b1;
      addr      <= alloc_addr;
      remaining <= alloc_cnt;
    end else if (done) begin
      busy      <= 1'b0;
      remaining <= '0;
    end else if (ack_hit) begin
      remaining <= remaining - CNT_W'(1);
    end
  end

  assert_busy_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> remaining != '0);
  assert_done_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_ack_on_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |-> busy);
  assert_alloc_when_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !busy);
endmodule

// File: rtl/iat_hazard.sv
module iat_hazard #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ENTRIES-1:0]             busy,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] entry_addr,
  input  logic                           ordered_mode,
  input  logic                           acc_valid,
  input  logic                           acc_write,
  input  logic [ADDR_W-1:0]              acc_addr,
  output logic                           addr_hit,
  output logic                           stall
);
  logic [ENTRIES-1:0] match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = busy[i] && (entry_addr[i] == acc_addr);
  end

  always_comb begin
    addr_hit = |match;
    stall    = acc_valid && ((!acc_write && addr_hit) || (ordered_mode && (|busy)));
  end

  assert_read_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && addr_hit) |-> stall);
  assert_ordered_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && ordered_mode && (busy != '0)) |-> stall);
  assert_idle_no_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy == '0) |-> !stall);
endmodule

// File: rtl/inval_ack_tracker.sv
module inval_ack_tracker #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 4,
  parameter int TAG_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ordered_mode,
  input  logic               wr_start,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_sharers,
  output logic               wr_ready,
  output logic [TAG_W-1:0]   wr_tag,
  input  logic               ack_valid,
  input  logic [TAG_W-1:0]   ack_tag,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [ADDR_W-1:0]  acc_addr,
  output logic [ENTRIES-1:0] done_vec,
  output logic               stall,
  output logic               ack_err
);
  logic [ENTRIES-1:0]             busy;
  logic [ENTRIES-1:0][ADDR_W-1:0] entry_addr;
  logic [ENTRIES-1:0][CNT_W-1:0]  entry_cnt;
  logic [ENTRIES-1:0]             entry_done;
  logic [ENTRIES-1:0]             alloc_en;
  logic [ENTRIES-1:0]             ack_hit;
  logic [ENTRIES-1:0]             free_onehot;
  logic                           free_any;
  logic                           accept;
  logic                           zero_cnt;
  logic                           ack_stray;
  logic                           addr_hit;

  iat_alloc #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_alloc (
    .busy        (busy),
    .free_any    (free_any),
    .free_tag    (wr_tag),
    .free_onehot (free_onehot)
  );

  always_comb begin
    wr_ready  = free_any;
    accept    = wr_start && free_any;
    zero_cnt  = (wr_sharers == '0);
    ack_stray = ack_valid && !busy[ack_tag];
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign alloc_en[i] = accept && free_onehot[i] && !zero_cnt;
    assign ack_hit[i]  = ack_valid && (ack_tag == TAG_W'(i)) && busy[i];
    assign done_vec[i] = entry_done[i] || (accept && free_onehot[i] && zero_cnt);

    iat_entry #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (alloc_en[i]),
      .alloc_addr (wr_addr),
      .alloc_cnt  (wr_sharers),
      .ack_hit    (ack_hit[i]),
      .busy       (busy[i]),
      .addr       (entry_addr[i]),
      .remaining  (entry_cnt[i]),
      .done       (entry_done[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ack_err <= 1'b0;
    else if (ack_stray) ack_err <= 1'b1;
  end

  iat_hazard #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_hazard (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .entry_addr   (entry_addr),
    .ordered_mode (ordered_mode),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_addr     (acc_addr),
    .addr_hit     (addr_hit),
    .stall        (stall)
  );

  assert_refused_no_alloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && !wr_ready) |=> ((busy & ~$past(busy)) == '0));
  assert_stray_sets_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stray |=> ack_err);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |=> ack_err);
  assert_zero_done_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && zero_cnt) |=> ((busy & ~$past(busy)) == '0));
endmodule

// File: tb/inval_ack_tracker_tb.sv
module inval_ack_tracker_tb;
  localparam int NE = 4;
  localparam int AW = 16;
  localparam int CW = 4;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic ordered_mode, wr_start, ack_valid, acc_valid, acc_write;
  logic [AW-1:0] wr_addr, acc_addr;
  logic [CW-1:0] wr_sharers;
  logic [TW-1:0] ack_tag, wr_tag;
  logic wr_ready, stall, ack_err;
  logic [NE-1:0] done_vec;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  bit m_busy [NE];
  int m_cnt  [NE];
  int m_addr [NE];
  bit m_err;
  logic [31:0] rnd = 32'h1234_5677;

  always #10 clk = ~clk;

  inval_ack_tracker #(.ENTRIES(NE), .ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ordered_mode(ordered_mode),
    .wr_start(wr_start), .wr_addr(wr_addr), .wr_sharers(wr_sharers),
    .wr_ready(wr_ready), .wr_tag(wr_tag),
    .ack_valid(ack_valid), .ack_tag(ack_tag),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .done_vec(done_vec), .stall(stall), .ack_err(ack_err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ordered_mode = 0; wr_start = 0; wr_addr = '0; wr_sharers = '0;
    ack_valid = 0; ack_tag = '0; acc_valid = 0; acc_write = 0; acc_addr = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NE; i++) begin m_busy[i] = 0; m_cnt[i] = 0; m_addr[i] = 0; end
    m_err = 0;
  endtask

  // One cycle: drive at negedge, compare before posedge, update model at posedge.
  task automatic step(input bit sv, input int sa, input int sh,
                      input bit av, input int at,
                      input bit cv, input bit cw, input int ca, input bit ord);
    int  ftag;
    bit  rdy, fire, hit, anyb;
    int  exp_done;
    bit  exp_stall;
    @(negedge clk);
    wr_start = sv; wr_addr = AW'(sa); wr_sharers = CW'(sh);
    ack_valid = av; ack_tag = TW'(at);
    acc_valid = cv; acc_write = cw; acc_addr = AW'(ca); ordered_mode = ord;
    #2;
    ftag = NE;
    for (int i = NE - 1; i >= 0; i--) if (!m_busy[i]) ftag = i;
    rdy  = (ftag < NE);
    fire = sv && rdy;
    exp_done = 0;
    if (av && m_busy[at] && m_cnt[at] == 1) exp_done |= (1 << at);
    if (fire && sh == 0) exp_done |= (1 << ftag);
    hit = 0; anyb = 0;
    for (int i = 0; i < NE; i++) begin
      if (m_busy[i]) anyb = 1;
      if (m_busy[i] && m_addr[i] == ca) hit = 1;
    end
    exp_stall = cv && ((!cw && hit) || (ord && anyb));
    check("R2 wr_ready", int'(wr_ready), int'(rdy));
    if (rdy) check("R2 wr_tag", int'(wr_tag), ftag);
    check("R3/R4 done_vec", int'(done_vec), exp_done);
    check("R5/R6 stall", int'(stall), int'(exp_stall));
    check("R8 ack_err", int'(ack_err), int'(m_err));
    @(posedge clk);
    if (av) begin
      if (!m_busy[at]) m_err = 1;
      else if (m_cnt[at] == 1) begin m_busy[at] = 0; m_cnt[at] = 0; end
      else m_cnt[at] = m_cnt[at] - 1;
    end
    if (fire && sh != 0) begin m_busy[ftag] = 1; m_cnt[ftag] = sh; m_addr[ftag] = sa; end
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    do_reset();
    // R1: reset state
    #2;
    check("R1 wr_ready", int'(wr_ready), 1);
    check("R1 stall", int'(stall), 0);
    check("R1 ack_err", int'(ack_err), 0);
    check("R1 done_vec", int'(done_vec), 0);

    // R4: zero-sharer stores complete on acceptance and keep tag 0 free
    for (int k = 0; k < 3; k++) step(1, 16 + k, 0, 0, 0, 1, 0, 16 + k, 1);

    // R2: fill all entries with counts 1..4, then a refused request
    for (int k = 0; k < NE; k++) step(1, 32 + k, k + 1, 0, 0, 0, 0, 0, 0);
    step(1, 99, 0, 0, 0, 1, 0, 99, 0);
    step(1, 98, 2, 0, 0, 1, 1, 32, 0);
    // R5/R6: reads of pending addresses, writes, ordered mode
    for (int k = 0; k < 6; k++) begin
      step(0, 0, 0, 0, 0, 1, 0, 30 + k, 0);
      step(0, 0, 0, 0, 0, 1, 1, 30 + k, 0);
      step(0, 0, 0, 0, 0, 1, 1, 30 + k, 1);
    end

    // R3: acknowledgements out of order across entries
    step(0, 0, 0, 1, 3, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0);   // entry 0 completes
    // R7 and R9: new store reuses entry 0 while entry 3 is acknowledged
    step(1, 40, 1, 1, 3, 1, 0, 32, 0);
    step(0, 0, 0, 1, 2, 1, 0, 40, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 3, 0, 0, 0, 0);
    step(0, 0, 0, 1, 2, 0, 0, 0, 0);
    step(0, 0, 0, 1, 3, 0, 0, 0, 0);
    step(0, 0, 0, 1, 2, 1, 0, 34, 1);

    // R8: stray acknowledgement leaves counts intact
    step(1, 50, 2, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 2, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0);
    idle();
    idle();

    // Random sweep with acknowledgements only to busy tags
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      int at;
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      at = int'(rnd[1:0]);
      step(rnd[2], int'(rnd[6:4]), int'(rnd[9:8]) * int'(rnd[10]) + int'(rnd[11]),
           rnd[12] && m_busy[at], at,
           rnd[13], rnd[14], int'(rnd[18:16]), rnd[20] && rnd[21]);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule